// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer-device events into the five-byte serial mouse packet and places the bytes in a circular receive queue. A host-side reader takes them out one at a time. Each event carries three button states and signed horizontal and vertical motion counts. The encoder builds a start byte from the buttons and two saturated motion bytes, with the vertical axis negated. It then appends two zero bytes and writes all five bytes into the queue, one per clock.

Events are first captured in a small holding buffer. An event that arrives while an earlier packet is still being written therefore waits its turn, and its bytes never mix with those of another packet. The byte queue shows its oldest byte on the read port together with a data-available flag. A one-cycle pop strobe consumes that byte. A byte written into a full queue is discarded, and an empty queue reads as zero.

Top module: `mouse_frame_queue`

## Requirements
- R1: The first byte of a packet is 0x87 with the buttons active low. A pressed left button clears bit 2, a pressed middle button clears bit 1 and a pressed right button clears bit 0.
- R2: The second byte is the horizontal count saturated to the range -127..+127 and sent as 8-bit two's complement. Values above the range give 0x7F and values below it give 0x81.
- R3: The third byte is the negated vertical count, saturated to -127..+127 and sent as 8-bit two's complement.
- R4: The fourth and fifth bytes of every packet are 0x00. The five bytes leave the queue in the order first, second, third, fourth, fifth.
- R5: A byte written while the queue already holds DEPTH bytes (default 16) is dropped. The bytes already stored are left unchanged.
- R6: While the queue is empty, the read data is 0x00 and the data-available flag is low. A pop on an empty queue has no effect.
- R7: After a pop, the data-available flag stays high as long as the queue still holds bytes. It drops after the last byte is popped.
- R8: Events on consecutive clocks each produce a complete packet. The packets come out in event order and their bytes are never interleaved.
- R9: After reset, and after any reset asserted mid-operation, the queue is empty: the data-available flag is low and the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | One-cycle event strobe |
| evt_dx_i | input | MW | Signed horizontal motion |
| evt_dy_i | input | MW | Signed vertical motion |
| btn_left_i | input | 1 | Left button pressed |
| btn_mid_i | input | 1 | Middle button pressed |
| btn_right_i | input | 1 | Right button pressed |
| pop_i | input | 1 | Consume the byte at the head of the queue |
| rd_data_o | output | 8 | Head byte, or 0x00 when the queue is empty |
| rd_avail_o | output | 1 | Queue holds at least one byte |

## Verification
A corrupted read or write pointer shows up at the ports on the first pop after it goes wrong: a byte of the wrong packet, or a stale byte. This is caught by comparing every byte of every packet in order. A count that drifts appears either as a data-available flag that stays high once the queue has drained, or as a flag that drops while bytes remain; both are checked after each pop. A fault in the encoder's byte sequencing produces a shifted or interleaved packet within five pops. The overflow case fills the queue past its depth, where the sixteenth byte and the empty read that follows it expose any wrong handling of a full queue.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
  localparam int unsigned FRAME_LEN = 5;
  localparam logic [7:0]  START_IDLE = 8'h87;
  localparam logic [7:0]  SAT_POS    = 8'h7F;
  localparam logic [7:0]  SAT_NEG    = 8'h81;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/mfq_ring.sv
module mfq_ring #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNTW-1:0]  count_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNTW-1:0]  count;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && (count != CNTW'(DEPTH));
  assign pop_ok  = pop_i && (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wptr] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o  = (count != '0) ? mem[rptr] : '0;
  assign count_o = count;
endmodule

// File: rtl/mfq_encoder.sv
module mfq_encoder
  import mfq_pkg::*;
#(
  parameter int unsigned MW = 10,
  localparam int unsigned EW = 3 + 2 * MW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_avail_i,
  input  logic [EW-1:0] evt_i,
  output logic          evt_take_o,
  output logic          push_o,
  output byte_t         push_data_o,
  output logic [2:0]    idx_o
);
  localparam logic signed [MW:0] LIM_HI = (MW + 1)'(127);
  localparam logic signed [MW:0] LIM_LO = -LIM_HI;

  logic [2:0]          btn;
  logic signed [MW:0]  dx_ext, dy_neg;
  byte_t               start_b, dx_b, dy_b;
  byte_t               r_start, r_dx, r_dy;
  logic                busy;
  logic [2:0]          idx;

  function automatic byte_t sat8(input logic signed [MW:0] v);
    if (v > LIM_HI)      return SAT_POS;
    else if (v < LIM_LO) return SAT_NEG;
    else                 return v[7:0];
  endfunction

  assign btn     = evt_i[EW-1 -: 3];
  assign dx_ext  = $signed({evt_i[2*MW-1], evt_i[2*MW-1 -: MW]});
  assign dy_neg  = '0 - $signed({evt_i[MW-1], evt_i[MW-1:0]});
  // buttons are active low in the start byte: left->bit2, mid->bit1, right->bit0
  assign start_b = START_IDLE ^ {5'b0, btn};
  assign dx_b    = sat8(dx_ext);
  assign dy_b    = sat8(dy_neg);

  assign evt_take_o = !busy && evt_avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy    <= 1'b0;
      idx     <= '0;
      r_start <= '0;
      r_dx    <= '0;
      r_dy    <= '0;
    end else if (evt_take_o) begin
      busy    <= 1'b1;
      idx     <= '0;
      r_start <= start_b;
      r_dx    <= dx_b;
      r_dy    <= dy_b;
    end else if (busy) begin
      if (idx == 3'(FRAME_LEN - 1)) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    case (idx)
      3'd0:    push_data_o = r_start;
      3'd1:    push_data_o = r_dx;
      3'd2:    push_data_o = r_dy;
      default: push_data_o = '0;
    endcase
  end

  assign push_o = busy;
  assign idx_o  = idx;
endmodule

// File: rtl/mouse_frame_queue.sv
module mouse_frame_queue
  import mfq_pkg::*;
#(
  parameter int unsigned MW        = 10,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned EVT_DEPTH = 4,
  localparam int unsigned EW   = 3 + 2 * MW,
  localparam int unsigned QCW  = $clog2(DEPTH + 1),
  localparam int unsigned ECW  = $clog2(EVT_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_valid_i,
  input  logic signed [MW-1:0] evt_dx_i,
  input  logic signed [MW-1:0] evt_dy_i,
  input  logic                 btn_left_i,
  input  logic                 btn_mid_i,
  input  logic                 btn_right_i,
  input  logic                 pop_i,
  output logic [7:0]           rd_data_o,
  output logic                 rd_avail_o
);
  logic [EW-1:0]  evt_in, evt_head;
  logic [ECW-1:0] evt_count;
  logic           evt_take;
  logic           q_push;
  byte_t          q_push_data;
  logic [2:0]     enc_idx;
  logic [QCW-1:0] q_count;

  assign evt_in = {btn_left_i, btn_mid_i, btn_right_i, evt_dx_i, evt_dy_i};

  mfq_ring #(.WIDTH(EW), .DEPTH(EVT_DEPTH)) u_evt_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (evt_valid_i),
    .push_data_i (evt_in),
    .pop_i       (evt_take),
    .head_o      (evt_head),
    .count_o     (evt_count)
  );

  mfq_encoder #(.MW(MW)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_avail_i (evt_count != '0),
    .evt_i       (evt_head),
    .evt_take_o  (evt_take),
    .push_o      (q_push),
    .push_data_o (q_push_data),
    .idx_o       (enc_idx)
  );

  mfq_ring #(.WIDTH(8), .DEPTH(DEPTH)) u_byte_q (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (q_push),
    .push_data_i (q_push_data),
    .pop_i       (pop_i),
    .head_o      (rd_data_o),
    .count_o     (q_count)
  );

  assign rd_avail_o = (q_count != '0);
endmodule

// File: rtl/mfq_checker.sv
module mfq_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned QCW  = $clog2(DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pop_i,
  input logic           rd_avail_o,
  input logic [7:0]     rd_data_o,
  input logic [QCW-1:0] q_count,
  input logic           q_push,
  input logic [2:0]     enc_idx
);
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_avail_o |-> rd_data_o == 8'h00); // R6

  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_avail_o && pop_i && !q_push) |=> !rd_avail_o); // R6

  AST_AVAIL_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && q_count > QCW'(1)) |=> rd_avail_o); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= QCW'(DEPTH)); // R5

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count == QCW'(DEPTH) && q_push && !pop_i) |=> q_count == QCW'(DEPTH)); // R5

  AST_FRAME_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && enc_idx != 3'd0) |-> ($past(q_push) && enc_idx == $past(enc_idx) + 3'd1)); // R8
endmodule

bind mouse_frame_queue mfq_checker #(.DEPTH(DEPTH)) u_mfq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pop_i      (pop_i),
  .rd_avail_o (rd_avail_o),
  .rd_data_o  (rd_data_o),
  .q_count    (q_count),
  .q_push     (q_push),
  .enc_idx    (enc_idx)
);

// File: tb/mouse_frame_queue_tb.sv
module mouse_frame_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 10;
  localparam int NVEC = 8;
  // {btn L,M,R}[46:44] dx[43:34] dy[33:24] exp byte0[23:16] byte1[15:8] byte2[7:0]
  localparam logic [46:0] VEC [NVEC] = '{
    {3'b000, 10'h000, 10'h000, 8'h87, 8'h00, 8'h00},
    {3'b100, 10'h005, 10'h003, 8'h83, 8'h05, 8'hFD},
    {3'b010, 10'h3FF, 10'h3FF, 8'h85, 8'hFF, 8'h01},
    {3'b001, 10'h07F, 10'h381, 8'h86, 8'h7F, 8'h7F},
    {3'b111, 10'h080, 10'h080, 8'h80, 8'h7F, 8'h81},
    {3'b000, 10'h380, 10'h380, 8'h87, 8'h81, 8'h7F},
    {3'b101, 10'h1FF, 10'h200, 8'h82, 8'h7F, 8'h7F},
    {3'b011, 10'h200, 10'h1FF, 8'h84, 8'h81, 8'h81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic signed [MW-1:0] dx = '0, dy = '0;
  logic bl = 1'b0, bm = 1'b0, br = 1'b0;
  logic pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_avail;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mouse_frame_queue #(.MW(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid),
    .evt_dx_i(dx), .evt_dy_i(dy),
    .btn_left_i(bl), .btn_mid_i(bm), .btn_right_i(br),
    .pop_i(pop), .rd_data_o(rd_data), .rd_avail_o(rd_avail)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic load_evt(input int n);
    {bl, bm, br} = VEC[n][46:44];
    dx = VEC[n][43:34];
    dy = VEC[n][33:24];
  endtask

  task automatic send_evt(input int n);
    @(negedge clk);
    load_evt(n);
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic pop_byte(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(rd_avail == 1'b1, "R7", {7'b0, rd_avail}, 8'h01);
    chk(rd_data == exp, req, rd_data, exp);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic read_frame(input int n);
    pop_byte(VEC[n][23:16], "R1");
    pop_byte(VEC[n][15:8],  "R2");
    pop_byte(VEC[n][7:0],   "R3");
    pop_byte(8'h00, "R4");
    pop_byte(8'h00, "R4");
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clks(3);
    // R9: reset state
    chk(rd_avail == 1'b0, "R9", {7'b0, rd_avail}, 8'h00);
    chk(rd_data == 8'h00, "R9", rd_data, 8'h00);
    rst_n = 1'b1;
    wait_clks(2);

    // vector table walk: R1 R2 R3 R4 R7
    for (int i = 0; i < NVEC; i++) begin
      send_evt(i);
      wait_clks(10);
      read_frame(i);
      @(negedge clk);
      chk(rd_avail == 1'b0, "R7", {7'b0, rd_avail}, 8'h00);
    end

    // R5: 20 bytes into a 16-deep queue
    for (int i = 0; i < 4; i++) begin
      send_evt(i);
      wait_clks(10);
    end
    read_frame(0);
    read_frame(1);
    read_frame(2);
    pop_byte(8'h86, "R5");
    @(negedge clk);
    chk(rd_avail == 1'b0, "R5", {7'b0, rd_avail}, 8'h00);
    // R6: empty read and pop on empty
    chk(rd_data == 8'h00, "R6", rd_data, 8'h00);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
    chk(rd_avail == 1'b0, "R6", {7'b0, rd_avail}, 8'h00);
    chk(rd_data == 8'h00, "R6", rd_data, 8'h00);

    // R8: events on consecutive clocks
    @(negedge clk);
    load_evt(1); evt_valid = 1'b1;
    @(negedge clk);
    load_evt(2);
    @(negedge clk);
    load_evt(4);
    @(negedge clk);
    evt_valid = 1'b0;
    wait_clks(25);
    read_frame(1);
    read_frame(2);
    read_frame(4);
    @(negedge clk);
    chk(rd_avail == 1'b0, "R8", {7'b0, rd_avail}, 8'h00);

    // R9: reset mid-operation
    send_evt(3);
    wait_clks(10);
    chk(rd_avail == 1'b1, "R9", {7'b0, rd_avail}, 8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rd_avail == 1'b0, "R9", {7'b0, rd_avail}, 8'h00);
    chk(rd_data == 8'h00, "R9", rd_data, 8'h00);
    rst_n = 1'b1;
    wait_clks(2);
    send_evt(6);
    wait_clks(10);
    read_frame(6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule